// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a clock generator. It listens on a two-wire serial bus (clock line and data line, both oversampled by the system clock), answers two fixed byte addresses, and keeps six 8-bit control registers that the rest of the chip reads in parallel. The data line is open-drain: the block never drives it high. It only asserts an enable that pulls the line low.

Writes are block transfers. After the write address the host sends two header bytes, a command code and a byte count. The block acknowledges both and discards them. The data bytes that follow land in register 0, then 1, and so on. A stop may come after any complete byte. Reads return a byte count first, then the six registers in ascending order. The host acknowledges each byte, and a not-acknowledge ends the read. A repeated start always restarts the sequence from the header. Register 0 is also decoded into named control fields for the output stage.

Top module: `serial_cfg_slave`

## Requirements
- R1: The block acknowledges only the 8-bit address bytes 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and all bytes after it are ignored until the next start.
- R2: In a write, the first two bytes after the address are each acknowledged. Their values never reach any register.
- R3: Write data bytes are each acknowledged and are stored in registers 0, 1, 2, ... in arrival order. Registers change only when a data byte is committed.
- R4: A stop after any complete data byte keeps every byte already received. Data bytes beyond register 5 are acknowledged but discarded.
- R5: A read returns the byte 0x06 first, then registers 0 to 5 in order. Every byte is sent MSB first.
- R6: When the host does not acknowledge a read byte, the block stops driving the data line and sends nothing more until the next start.
- R7: After reset, register 0 is 0x00 and registers 1 to 5 are 0xFF.
- R8: Register 0 decodes as follows. Bit 0 = all outputs tristated. Bit 1 = spread spectrum enabled. Bit 7 = down spread (0 gives center spread). Bit 3 = frequency taken from the register (0 gives the strap pins). The 4-bit frequency code is {bit2, bit6, bit5, bit4}, with bit 2 as its MSB.
- R9: A repeated start returns the sequencer to the address byte. A write after it again treats its first two bytes as headers and starts data at register 0.
- R10: The data-line enable changes only after a falling edge of the clock line, or on a start or stop condition. It never changes while the clock line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level (asynchronous) |
| sda_in | input | 1 | Serial data line level (asynchronous) |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| cfg_regs | output | NREG*8 | Register bank, register k at bits [8k+7:8k] |
| out_tristate | output | 1 | Register 0 bit 0 |
| spread_en | output | 1 | Register 0 bit 1 |
| spread_down | output | 1 | Register 0 bit 7 |
| freq_by_reg | output | 1 | Register 0 bit 3 |
| freq_code | output | 4 | {reg0[2], reg0[6:4]} |

## Verification
The bench uses the default parameters: six registers, a two-flop synchronizer, device address 0x69 and returned count 6. It drives the bus with a quarter-bit of 8 system clocks, so the three-cycle path through the synchronizer and edge detector always settles inside one bus phase. This short bit time keeps full six-register transfers, overflow past the last register, early termination, and repeated starts into both directions cheap enough to run back to back. The address 0xA0 exercises the non-matching path.

// File: rtl/cfg_pkg.sv
// Shared types for the serial configuration slave.
// Assumes: bytes are 8 bits and are transferred MSB first.
package cfg_pkg;
    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } seq_state_t;
endpackage

// File: rtl/line_sync.sv
// Synchronizes one asynchronous bus line into the clk domain.
// It also gives the level one cycle earlier, for edge detection.
// Assumes: the idle bus level is high, so reset fills the chain with ones.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_prev
);
    logic [STAGES:0] pipe;

    // Shift the line level through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], d};
    end

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/cfg_regbank.sv
// Parallel configuration register bank with one write port.
// Assumes: wr_idx is only meaningful while wr_en is high.
module cfg_regbank #(
    parameter int NREG = 6,
    parameter int IDXW = 4,
    parameter logic [NREG*8-1:0] RST_VALS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] regs
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // Hold one register; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i*8 +: 8] <= RST_VALS[i*8 +: 8];
            else if (wr_en && wr_idx == IDXW'(i))
                regs[i*8 +: 8] <= wr_data;
        end
    end
endmodule

// File: rtl/cfg_seq.sv
// Byte sequencer for the serial configuration slave. It detects start and
// stop, matches the address, skips two header bytes on writes, and
// commits data to an ascending register index. On reads it sends the byte
// count and then the registers.
// Assumes: scl/sda are already synchronized; the host honours standard
// timing, so each bus phase lasts several clk cycles.
module cfg_seq
    import cfg_pkg::*;
#(
    parameter int          NREG       = 6,
    parameter int          IDXW       = 4,
    parameter logic [6:0]  DEV_ADDR   = 7'h69,
    parameter logic [7:0]  BYTE_COUNT = 8'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic [NREG*8-1:0] rd_regs,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDXW-1:0]   wr_idx,
    output logic [7:0]        wr_data,
    output logic              start_p,
    output logic              stop_p
);
    localparam logic [IDXW-1:0] IDX_MAX  = '1;
    localparam logic [3:0]      BITS_END = 4'(BYTE_BITS);

    seq_state_t      state;
    logic [3:0]      bit_cnt;
    logic [IDXW-1:0] byte_idx;
    logic [7:0]      shreg;
    logic            is_read;
    logic            addr_phase;
    logic            host_ack;

    logic            scl_rise, scl_fall;
    logic [IDXW-1:0] idx_next;
    logic [7:0]      tx_next;

    // Decode the bus events from the current and previous sampled levels.
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_p  = scl_s & scl_p & sda_p & ~sda_s;
        stop_p   = scl_s & scl_p & ~sda_p & sda_s;
    end

    // Next byte index, saturating so a long write never wraps.
    assign idx_next = (byte_idx == IDX_MAX) ? byte_idx : byte_idx + 1'b1;

    // Pick the byte that follows in a read: index 0 is the count, then the registers.
    always_comb begin
        tx_next = 8'h00;
        if (idx_next == '0) tx_next = BYTE_COUNT;
        for (int k = 0; k < NREG; k++)
            if (int'(idx_next) == k + 1) tx_next = rd_regs[k*8 +: 8];
    end

    // Commit a data byte when its eighth bit has been taken, as long as its index is in range.
    always_comb begin
        wr_idx  = byte_idx - IDXW'(2);
        wr_data = shreg;
        wr_en   = (state == ST_RX) && scl_fall && (bit_cnt == BITS_END) &&
                  !addr_phase && (byte_idx >= IDXW'(2)) && (int'(wr_idx) < NREG);
    end

    // Main sequencer: start and stop override everything, and the rest moves on clock-line edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            shreg      <= '0;
            is_read    <= 1'b0;
            addr_phase <= 1'b0;
            host_ack   <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (start_p) begin
            state      <= ST_RX;
            addr_phase <= 1'b1;
            bit_cnt    <= '0;
            byte_idx   <= '0;
            sda_oe     <= 1'b0;
        end else if (stop_p) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && bit_cnt < BITS_END) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == BITS_END) begin
                        if (addr_phase && shreg[7:1] != DEV_ADDR) begin
                            state <= ST_IDLE;
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_RX_ACK;
                            if (addr_phase) is_read <= shreg[0];
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bit_cnt    <= '0;
                        addr_phase <= 1'b0;
                        if (addr_phase && is_read) begin
                            shreg  <= BYTE_COUNT;
                            sda_oe <= ~BYTE_COUNT[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                            if (!addr_phase) byte_idx <= idx_next;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == BITS_END) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            byte_idx <= idx_next;
                            shreg    <= tx_next;
                            sda_oe   <= ~tx_next[7];
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/serial_cfg_slave.sv
// Top of the serial configuration slave. It synchronizes the bus lines,
// runs the byte sequencer, holds the register bank and decodes the
// control fields of register 0.
// Assumes: the pad turns sda_oe into a pull-down; register 0 always exists.
module serial_cfg_slave
    import cfg_pkg::*;
#(
    parameter int                NREG        = 6,
    parameter int                SYNC_STAGES = 2,
    parameter logic [6:0]        DEV_ADDR    = 7'h69,
    parameter logic [7:0]        BYTE_COUNT  = 8'd6,
    parameter logic [NREG*8-1:0] RST_VALS    = {{(NREG-1){8'hFF}}, 8'h00}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs,
    output logic              out_tristate,
    output logic              spread_en,
    output logic              spread_down,
    output logic              freq_by_reg,
    output logic [3:0]        freq_code
);
    localparam int IDXW = $clog2(NREG + 3);

    logic            scl_s, scl_p, sda_s, sda_p;
    logic            wr_en, start_p, stop_p;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;

    line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s), .q_prev(scl_p));

    line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s), .q_prev(sda_p));

    cfg_seq #(
        .NREG(NREG), .IDXW(IDXW), .DEV_ADDR(DEV_ADDR), .BYTE_COUNT(BYTE_COUNT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
        .rd_regs(cfg_regs), .sda_oe(sda_oe),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .start_p(start_p), .stop_p(stop_p));

    cfg_regbank #(.NREG(NREG), .IDXW(IDXW), .RST_VALS(RST_VALS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs(cfg_regs));

    // Break register 0 out into its named control fields.
    always_comb begin
        out_tristate = cfg_regs[0];
        spread_en    = cfg_regs[1];
        freq_by_reg  = cfg_regs[3];
        spread_down  = cfg_regs[7];
        freq_code    = {cfg_regs[2], cfg_regs[6:4]};
    end
endmodule

// File: rtl/cfg_slave_checker.sv
// Protocol checks for serial_cfg_slave, attached by bind.
// Assumes: it sees the top's synchronized clock line and internal pulses.
module cfg_slave_checker #(
    parameter int NREG = 6,
    parameter int IDXW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_p,
    input logic              stop_p,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [IDXW-1:0]   wr_idx,
    input logic [NREG*8-1:0] cfg_regs
);
    p_stop_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !sda_oe);

    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !sda_oe);

    p_oe_quiet_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_p) && !$past(stop_p)) |-> $stable(sda_oe));

    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));
endmodule

bind serial_cfg_slave cfg_slave_checker #(.NREG(NREG), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_p(start_p),
    .stop_p(stop_p), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .cfg_regs(cfg_regs));

// File: tb/serial_cfg_slave_tb_top.sv
module serial_cfg_slave_tb_top;
    localparam int NREG = 6;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_regs;
    logic out_tristate, spread_en, spread_down, freq_by_reg;
    logic [3:0] freq_code;

    int checks = 0;
    int fails  = 0;
    int oe_viol = 0;
    int scl_hi_cnt = 0;
    logic prev_oe = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf [16];

    always #2 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    serial_cfg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs), .out_tristate(out_tristate),
        .spread_en(spread_en), .spread_down(spread_down),
        .freq_by_reg(freq_by_reg), .freq_code(freq_code));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_q(1);
        scl_drv = 1'b1; wait_q(1);
        sda_drv = 1'b0; wait_q(1);
        scl_drv = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_q(1);
        scl_drv = 1'b1; wait_q(1);
        sda_drv = 1'b1; wait_q(1);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_q(1);
            scl_drv = 1'b1; wait_q(2);
            scl_drv = 1'b0; wait_q(1);
        end
        sda_drv = 1'b1; wait_q(1);
        scl_drv = 1'b1; wait_q(1);
        acked = (sda_line == 1'b0);
        wait_q(1);
        scl_drv = 1'b0; wait_q(1);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1);
            scl_drv = 1'b1; wait_q(1);
            b[i] = sda_line;
            wait_q(1);
            scl_drv = 1'b0;
        end
        wait_q(1);
        sda_drv = give_ack ? 1'b0 : 1'b1; wait_q(1);
        scl_drv = 1'b1; wait_q(2);
        scl_drv = 1'b0; wait_q(1);
        sda_drv = 1'b1;
    endtask

    // Block write of n data bytes from wbuf; updates the model.
    task automatic do_write(input int n, input string req);
        logic a;
        int nacks = 0;
        bus_start();
        put_byte(8'hD2, a); if (!a) nacks++;
        put_byte(8'h5A, a); if (!a) nacks++;
        put_byte(8'hC3, a); if (!a) nacks++;
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], a); if (!a) nacks++;
            if (i < NREG) model[i] = wbuf[i];
        end
        bus_stop();
        chk(req, "missing acks in write", nacks, 0);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, $sformatf("reg%0d", i), cfg_regs[i*8 +: 8], model[i]);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h00 : 8'hFF;
        check_regs("R7");
        chk("R7", "sda_oe after reset", sda_oe, 0);
        chk("R8", "tristate at reset", out_tristate, 0);
        chk("R8", "freq code at reset", freq_code, 0);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        put_byte(8'hA0, a);
        chk("R1", "ack on foreign address", a, 0);
        put_byte(8'h00, a);
        put_byte(8'h00, a);
        put_byte(8'h3C, a);
        chk("R1", "ack after foreign address", a, 0);
        bus_stop();
        check_regs("R1");
    endtask

    task automatic t_full_write();
        wbuf[0] = 8'h00; wbuf[1] = 8'h12; wbuf[2] = 8'h34;
        wbuf[3] = 8'h56; wbuf[4] = 8'h78; wbuf[5] = 8'h9A;
        do_write(6, "R3");
        check_regs("R3");
        chk("R2", "header not stored in reg1", cfg_regs[15:8], 8'h12);
    endtask

    task automatic t_decode();
        wbuf[0] = 8'h8B;
        do_write(1, "R8");
        chk("R8", "tristate", out_tristate, 1);
        chk("R8", "spread enable", spread_en, 1);
        chk("R8", "down spread", spread_down, 1);
        chk("R8", "freq by reg", freq_by_reg, 1);
        chk("R8", "freq code 0x8B", freq_code, 4'h0);
        wbuf[0] = 8'h54;
        do_write(1, "R8");
        chk("R8", "freq code 0x54", freq_code, 4'hD);
        chk("R8", "tristate off", out_tristate, 0);
        chk("R8", "center spread", spread_down, 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, a);
        chk("R1", "ack on read address", a, 1);
        get_byte(1'b1, b);
        chk("R5", "byte count", b, 8'h06);
        for (int i = 0; i < NREG; i++) begin
            get_byte(i != NREG - 1, b);
            chk("R5", $sformatf("read reg%0d", i), b, model[i]);
        end
        bus_stop();
    endtask

    task automatic t_partial();
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        do_write(2, "R4");
        check_regs("R4");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h40 + 8'(i);
        do_write(8, "R4");
        check_regs("R4");
    endtask

    task automatic t_early_nack();
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD3, a);
        get_byte(1'b1, b);
        get_byte(1'b0, b);
        chk("R6", "reg0 before nack", b, model[0]);
        wait_q(2);
        chk("R6", "line released after nack", sda_oe, 0);
        bus_stop();
        chk("R6", "line released after stop", sda_oe, 0);
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h01, a); put_byte(8'h02, a);
        put_byte(8'h11, a);
        model[0] = 8'h11;
        bus_start();
        put_byte(8'hD2, a);
        put_byte(8'h33, a); put_byte(8'h44, a);
        put_byte(8'h22, a);
        chk("R9", "ack after restart", a, 1);
        model[0] = 8'h22;
        bus_stop();
        check_regs("R9");
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a);
        bus_start();
        put_byte(8'hD3, a);
        get_byte(1'b1, b);
        chk("R9", "count after restart to read", b, 8'h06);
        get_byte(1'b0, b);
        chk("R9", "reg0 after restart to read", b, model[0]);
        bus_stop();
    endtask

    // Watch for the enable changing while the clock line has been high for a while.
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_drv) scl_hi_cnt++; else scl_hi_cnt = 0;
            if (scl_hi_cnt >= 6 && sda_oe !== prev_oe) oe_viol++;
            prev_oe = sda_oe;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_bad_addr();
        t_full_write();
        t_read();
        t_decode();
        t_partial();
        t_overflow();
        t_read();
        t_early_nack();
        t_restart();
        chk("R10", "enable changes with clock high", oe_viol, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule